// File: doc/BRIEF.md
# Thread Yield Decision Unit

This block settles what happens when a running hardware thread context issues a yield request. On a request strobe it looks at the caller's signed operand, a qualifier mask, the caller's own thread flag and an exception-enable bit for yields. It also sees the status of every context in the core: the virtual processor each context is bound to, and its dynamically-allocatable, halted and activated flags. From these it decides whether the caller is deactivated, whether a thread fault is raised and with which exception code, and it always returns the operand masked by the qualifier.

The operand sets the mode. A zero operand asks to give up the context. The caller is deactivated only when at least one other context on the same virtual processor is still active. A positive operand is checked against the mask. A negative operand other than -2 can trap when yield exceptions are enabled and the caller's flag is set. An operand of -2 never traps. The decision logic is one combinational stage, and every output is registered, so results appear one clock after the request.

Top module: `yld_unit`

## Requirements
- R1: While rst_ni is low, and directly after reset, done_o, deact_o and fault_o are 0, and exc_code_o and result_o are 0.
- R2: done_o is 1 in exactly the cycle after a cycle in which req_i is 1. deact_o and fault_o can be 1 only in such a cycle, and they are never 1 together.
- R3: For every request, result_o becomes operand_i AND mask_i, one cycle after the request.
- R4: Context i counts as an active sibling only if all of the following hold: ctx_vp_i[i] equals self_vp_i, i differs from self_idx_i, ctx_da_i[i] is 1, ctx_halt_i[i] is 0, and ctx_act_i[i] is 1.
- R5: Only contexts with index 0 to last_idx_i inclusive are examined. The number of contexts examined is the field value plus one.
- R6: A request with operand 0 gives deact_o=1 when an active sibling exists, with fault_o=0 and exc_code_o=0.
- R7: A request with operand 0 and no active sibling gives deact_o=0, fault_o=0 and exc_code_o=0.
- R8: A request with a positive operand (MSB 0, non-zero) that has any bit set outside mask_i gives fault_o=1 with exc_code_o=2. A positive operand inside the mask gives fault_o=0 and exc_code_o=0.
- R9: A request with a negative operand (MSB 1) other than -2 gives fault_o=1 with exc_code_o=4 when ysi_en_i and dt_i are both 1. Otherwise it gives fault_o=0 and exc_code_o=0.
- R10: A request with operand -2 (all ones except bit 0) never gives a fault or a deactivation.
- R11: exc_code_o and result_o hold their values in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Yield request strobe |
| operand_i | input | DATA_W | Signed source operand |
| mask_i | input | DATA_W | Yield qualifier mask |
| self_vp_i | input | VP_W | Caller's virtual processor |
| self_idx_i | input | CTX_W | Caller's context index |
| last_idx_i | input | CTX_W | Highest context index examined (count minus one) |
| dt_i | input | 1 | Caller's thread flag gating the yield trap |
| ysi_en_i | input | 1 | Yield exception enable |
| ctx_vp_i | input | NUM_CTX x VP_W | Virtual processor bound to each context |
| ctx_da_i | input | NUM_CTX | Dynamically-allocatable flag per context |
| ctx_halt_i | input | NUM_CTX | Halted flag per context |
| ctx_act_i | input | NUM_CTX | Activated flag per context |
| done_o | output | 1 | Decision valid strobe |
| deact_o | output | 1 | Deactivate caller strobe |
| fault_o | output | 1 | Thread fault strobe |
| exc_code_o | output | 3 | Exception code (0, 2 or 4) |
| result_o | output | DATA_W | Masked operand returned to caller |

## Verification
The assertions check the timing and consistency properties on every cycle. These are the one-cycle done strobe, the exclusivity of deactivation and fault, the masked result, legal exception codes, the -2 exemption, the trap gating on the enable and caller flag, and the holding of the outputs between requests. The sibling qualification depends on the whole context status vector and on the examined range, so only the bench's scenarios can show it. These scenarios remove one qualifying condition at a time, and they move the sibling across the range limit.

// File: rtl/yld_pkg.sv
package yld_pkg;
  localparam int EXC_W = 3;

  typedef enum logic [EXC_W-1:0] {
    EXC_NONE = 3'd0,
    EXC_MASK = 3'd2,
    EXC_YSI  = 3'd4
  } yld_exc_e;

  typedef enum logic [1:0] {
    OP_ZERO,
    OP_POS,
    OP_NEG_EXEMPT,
    OP_NEG
  } yld_op_e;

  typedef struct packed {
    logic     deact;
    logic     fault;
    yld_exc_e code;
  } yld_dec_t;
endpackage

// File: rtl/yld_sibling_scan.sv
module yld_sibling_scan #(
  parameter int NUM_CTX = 4,
  parameter int VP_W    = 2,
  parameter int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [NUM_CTX-1:0][VP_W-1:0] ctx_vp_i,
  input  logic [NUM_CTX-1:0]           ctx_da_i,
  input  logic [NUM_CTX-1:0]           ctx_halt_i,
  input  logic [NUM_CTX-1:0]           ctx_act_i,
  input  logic [VP_W-1:0]              self_vp_i,
  input  logic [CTX_W-1:0]             self_idx_i,
  input  logic [CTX_W-1:0]             last_idx_i,
  output logic                         sib_o
);
  logic [NUM_CTX-1:0] hit;

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    logic in_range, same_vp, not_self, live;
    assign in_range = (CTX_W'(i) <= last_idx_i);
    assign same_vp  = (ctx_vp_i[i] == self_vp_i);
    assign not_self = (CTX_W'(i) != self_idx_i);
    assign live     = ctx_da_i[i] & ~ctx_halt_i[i] & ctx_act_i[i];
    assign hit[i]   = in_range & same_vp & not_self & live;
  end

  assign sib_o = |hit;
endmodule

// File: rtl/yld_op_class.sv
module yld_op_class
  import yld_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  output yld_op_e           cls_o,
  output logic              outside_o,
  output logic [DATA_W-1:0] result_o
);
  localparam logic [DATA_W-1:0] NEG_TWO = {{(DATA_W-1){1'b1}}, 1'b0};

  always_comb begin
    if (operand_i == '0)              cls_o = OP_ZERO;
    else if (!operand_i[DATA_W-1])    cls_o = OP_POS;
    else if (operand_i == NEG_TWO)    cls_o = OP_NEG_EXEMPT;
    else                              cls_o = OP_NEG;
  end

  assign outside_o = |(operand_i & ~mask_i);
  assign result_o  = operand_i & mask_i;
endmodule

// File: rtl/yld_decide.sv
module yld_decide
  import yld_pkg::*;
(
  input  yld_op_e  cls_i,
  input  logic     outside_i,
  input  logic     sib_i,
  input  logic     dt_i,
  input  logic     ysi_en_i,
  output yld_dec_t dec_o
);
  always_comb begin
    dec_o = '{deact: 1'b0, fault: 1'b0, code: EXC_NONE};
    unique case (cls_i)
      OP_ZERO: dec_o.deact = sib_i;
      OP_POS: if (outside_i) begin
        dec_o.fault = 1'b1;
        dec_o.code  = EXC_MASK;
      end
      OP_NEG: if (ysi_en_i && dt_i) begin
        dec_o.fault = 1'b1;
        dec_o.code  = EXC_YSI;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/yld_unit.sv
module yld_unit
  import yld_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int VP_W    = 2,
  parameter int DATA_W  = 32,
  parameter int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [DATA_W-1:0]            operand_i,
  input  logic [DATA_W-1:0]            mask_i,
  input  logic [VP_W-1:0]              self_vp_i,
  input  logic [CTX_W-1:0]             self_idx_i,
  input  logic [CTX_W-1:0]             last_idx_i,
  input  logic                         dt_i,
  input  logic                         ysi_en_i,
  input  logic [NUM_CTX-1:0][VP_W-1:0] ctx_vp_i,
  input  logic [NUM_CTX-1:0]           ctx_da_i,
  input  logic [NUM_CTX-1:0]           ctx_halt_i,
  input  logic [NUM_CTX-1:0]           ctx_act_i,
  output logic                         done_o,
  output logic                         deact_o,
  output logic                         fault_o,
  output logic [EXC_W-1:0]             exc_code_o,
  output logic [DATA_W-1:0]            result_o
);
  logic              sib;
  yld_op_e           cls;
  logic              outside;
  logic [DATA_W-1:0] res_d;
  yld_dec_t          dec;

  yld_sibling_scan #(.NUM_CTX(NUM_CTX), .VP_W(VP_W), .CTX_W(CTX_W)) u_scan (
    .ctx_vp_i   (ctx_vp_i),
    .ctx_da_i   (ctx_da_i),
    .ctx_halt_i (ctx_halt_i),
    .ctx_act_i  (ctx_act_i),
    .self_vp_i  (self_vp_i),
    .self_idx_i (self_idx_i),
    .last_idx_i (last_idx_i),
    .sib_o      (sib)
  );

  yld_op_class #(.DATA_W(DATA_W)) u_cls (
    .operand_i (operand_i),
    .mask_i    (mask_i),
    .cls_o     (cls),
    .outside_o (outside),
    .result_o  (res_d)
  );

  yld_decide u_dec (
    .cls_i     (cls),
    .outside_i (outside),
    .sib_i     (sib),
    .dt_i      (dt_i),
    .ysi_en_i  (ysi_en_i),
    .dec_o     (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      deact_o    <= 1'b0;
      fault_o    <= 1'b0;
      exc_code_o <= '0;
      result_o   <= '0;
    end else begin
      done_o  <= req_i;
      deact_o <= req_i & dec.deact;
      fault_o <= req_i & dec.fault;
      if (req_i) begin
        exc_code_o <= dec.code;
        result_o   <= res_d;
      end
    end
  end
endmodule

// File: rtl/yld_unit_chk.sv
module yld_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              dt_i,
  input logic              ysi_en_i,
  input logic              done_o,
  input logic              deact_o,
  input logic              fault_o,
  input logic [2:0]        exc_code_o,
  input logic [DATA_W-1:0] result_o
);
  localparam logic [DATA_W-1:0] NEG_TWO = {{(DATA_W-1){1'b1}}, 1'b0};

  p_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);
  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(deact_o && fault_o));
  p_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deact_o || fault_o) |-> done_o);
  p_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (result_o == $past(operand_i & mask_i)));
  p_zero_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && operand_i != '0) |=> !deact_o);
  p_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (exc_code_o == 3'd2 || exc_code_o == 3'd4));
  p_inmask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !operand_i[DATA_W-1] && ((operand_i & ~mask_i) == '0)) |=> !fault_o);
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && operand_i[DATA_W-1] && !(dt_i && ysi_en_i)) |=> !fault_o);
  p_exempt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && operand_i == NEG_TWO) |=> (!fault_o && !deact_o));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(exc_code_o) && $stable(result_o)));
endmodule

bind yld_unit yld_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .operand_i  (operand_i),
  .mask_i     (mask_i),
  .dt_i       (dt_i),
  .ysi_en_i   (ysi_en_i),
  .done_o     (done_o),
  .deact_o    (deact_o),
  .fault_o    (fault_o),
  .exc_code_o (exc_code_o),
  .result_o   (result_o)
);

// File: tb/yld_unit_tb_top.sv
module yld_unit_tb_top;
  localparam int CLK_T   = 10;
  localparam int NUM_CTX = 4;
  localparam int VP_W    = 2;
  localparam int DATA_W  = 32;
  localparam int CTX_W   = 2;

  typedef struct packed {
    logic [31:0] op;
    logic [31:0] mask;
    logic        dt;
    logic        ysi;
    logic        e_deact;
    logic        e_fault;
    logic [2:0]  e_code;
  } vec_t;

  // sibling present in base setup, so operand 0 deactivates
  localparam vec_t VECS [10] = '{
    '{32'h0000_0000, 32'h0000_00FF, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
    '{32'h0000_0005, 32'h0000_000F, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    '{32'h0000_0015, 32'h0000_000F, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2},
    '{32'hFFFF_FFFF, 32'h0000_00FF, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4},
    '{32'hFFFF_FFFF, 32'h0000_00FF, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{32'hFFFF_FFFF, 32'h0000_00FF, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    '{32'hFFFF_FFFE, 32'h0000_000F, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    '{32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4},
    '{32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [DATA_W-1:0] operand_i = '0, mask_i = '0;
  logic [VP_W-1:0] self_vp_i = '0;
  logic [CTX_W-1:0] self_idx_i = '0, last_idx_i = '0;
  logic dt_i = 1'b0, ysi_en_i = 1'b0;
  logic [NUM_CTX-1:0][VP_W-1:0] ctx_vp_i = '0;
  logic [NUM_CTX-1:0] ctx_da_i = '0, ctx_halt_i = '0, ctx_act_i = '0;
  logic done_o, deact_o, fault_o;
  logic [2:0] exc_code_o;
  logic [DATA_W-1:0] result_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  yld_unit #(.NUM_CTX(NUM_CTX), .VP_W(VP_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .operand_i(operand_i),
    .mask_i(mask_i), .self_vp_i(self_vp_i), .self_idx_i(self_idx_i),
    .last_idx_i(last_idx_i), .dt_i(dt_i), .ysi_en_i(ysi_en_i),
    .ctx_vp_i(ctx_vp_i), .ctx_da_i(ctx_da_i), .ctx_halt_i(ctx_halt_i),
    .ctx_act_i(ctx_act_i), .done_o(done_o), .deact_o(deact_o),
    .fault_o(fault_o), .exc_code_o(exc_code_o), .result_o(result_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // caller ctx1 on vp1; ctx0 is a live sibling, ctx2/3 on other vps
  task automatic base_setup();
    self_vp_i  = 2'd1;
    self_idx_i = 2'd1;
    last_idx_i = 2'd3;
    ctx_vp_i   = '{2'd3, 2'd2, 2'd1, 2'd1};
    ctx_da_i   = 4'b1111;
    ctx_halt_i = 4'b0000;
    ctx_act_i  = 4'b1111;
  endtask

  // one request; returns at the negedge after the output register updated
  task automatic issue(input logic [31:0] op, input logic [31:0] mk,
                       input logic dt, input logic ysi);
    @(negedge clk);
    operand_i = op; mask_i = mk; dt_i = dt; ysi_en_i = ysi; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    operand_i = 32'hDEAD_BEEF; mask_i = 32'hFFFF_FFFF;
  endtask

  task automatic zero_yield(input string req, input logic exp_deact);
    issue(32'h0, 32'hFF, 1'b1, 1'b1);
    chk(req, "deact", 32'(deact_o), 32'(exp_deact));
    chk(req, "fault", 32'(fault_o), 32'h0);
  endtask

  initial begin
    #(CLK_T*100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    base_setup();
    #(CLK_T*2 + 1);
    // R1: reset state
    chk("R1", "done", 32'(done_o), 0);
    chk("R1", "deact", 32'(deact_o), 0);
    chk("R1", "fault", 32'(fault_o), 0);
    chk("R1", "code", 32'(exc_code_o), 0);
    chk("R1", "result", result_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", 32'(done_o), 0);

    for (int k = 0; k < 10; k++) begin
      issue(VECS[k].op, VECS[k].mask, VECS[k].dt, VECS[k].ysi);
      chk("R2", $sformatf("done v%0d", k), 32'(done_o), 1);
      chk("R3", $sformatf("result v%0d", k), result_o, VECS[k].op & VECS[k].mask);
      chk("R6/R8/R9/R10", $sformatf("deact v%0d", k), 32'(deact_o), 32'(VECS[k].e_deact));
      chk("R8/R9/R10", $sformatf("fault v%0d", k), 32'(fault_o), 32'(VECS[k].e_fault));
      chk("R8/R9", $sformatf("code v%0d", k), 32'(exc_code_o), 32'(VECS[k].e_code));
      @(negedge clk);
      // R11: held, strobes gone
      chk("R2", $sformatf("done drop v%0d", k), 32'(done_o), 0);
      chk("R2", $sformatf("fault drop v%0d", k), 32'(fault_o), 0);
      chk("R11", $sformatf("code hold v%0d", k), 32'(exc_code_o), 32'(VECS[k].e_code));
      chk("R11", $sformatf("result hold v%0d", k), result_o, VECS[k].op & VECS[k].mask);
    end

    // R4: remove one sibling condition at a time
    base_setup(); ctx_vp_i[0] = 2'd2;   zero_yield("R4 vp mismatch / R7", 1'b0);
    base_setup(); ctx_da_i[0] = 1'b0;   zero_yield("R4 da=0 / R7", 1'b0);
    base_setup(); ctx_halt_i[0] = 1'b1; zero_yield("R4 halted / R7", 1'b0);
    base_setup(); ctx_act_i[0] = 1'b0;  zero_yield("R4 inactive / R7", 1'b0);
    base_setup(); ctx_vp_i[1] = 2'd2; self_idx_i = 2'd0;
    zero_yield("R4 self excluded / R7", 1'b0);
    chk("R7", "code", 32'(exc_code_o), 0);
    base_setup(); zero_yield("R6 sibling present", 1'b1);
    chk("R6", "code", 32'(exc_code_o), 0);

    // R5: sibling only at ctx3
    base_setup(); ctx_vp_i[0] = 2'd0; ctx_vp_i[3] = 2'd1;
    last_idx_i = 2'd2; zero_yield("R5 beyond range", 1'b0);
    last_idx_i = 2'd3; zero_yield("R5 at range end", 1'b1);
    ctx_vp_i[3] = 2'd0; ctx_vp_i[0] = 2'd1;
    last_idx_i = 2'd0; zero_yield("R5 single context", 1'b1);

    // R1: mid-run reset clears
    issue(32'h15, 32'hF, 1'b0, 1'b0);
    @(negedge clk); rst_ni = 1'b0; #1;
    chk("R1", "code after reset", 32'(exc_code_o), 0);
    chk("R1", "result after reset", result_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule